// File: doc/BRIEF.md
# Region Pattern Fill-and-Verify Sequencer

This block drives a simple synchronous word memory port through a fixed series of seven pattern tests over a region given by a base byte address and a byte length. Each test first writes every word of the current test window with a generated value and only then reads the window back, comparing each returned word with the value that was written. The first wrong word ends the whole run and its location, the expected word and the word actually read are held for inspection. Data-line and address-line checks are expected to have run earlier and are not part of this block.

Two coverage modes exist. The slow mode tests the whole (trimmed) region as one window. The normal mode samples the region: for every complete block of `BLOCK_BYTES` it tests a window of `WIN_BYTES` at the bottom of the block and another at the top of the block. Throughout the run a watchdog kick pulse is produced at a regular word stride and after every finished test, so that a long run does not trip a system watchdog.

Top module: `mtest_seq`

## Requirements
- R1: Every window runs seven tests in this fixed order, with test value written as a function of the window-relative word index i: all zeros, all ones, 0x55555555 (bit pairs 01), 0xAAAAAAAA (bit pairs 10), a walking one equal to 1 shifted left by (i mod DATA_W), i itself, and the bitwise inverse of i.
- R2: Within a test, every word of the window is written (ascending address, one write per cycle) before the first read is issued; reads then run in ascending address order, one read per two cycles, with `mem_rdata` taken one cycle after `mem_re`; writes and reads never overlap.
- R3: The first read word that differs from its expected value stops the run: no further reads or writes happen, `fail` is set, and `fail_addr`, `fail_expect`, `fail_read` hold the byte address, expected word and read word of that mismatch.
- R4: `wdog_kick` pulses on every write cycle and every read-issue cycle whose window-relative word index is a multiple of `KICK_WORDS`, and once after each completed test.
- R5: In normal mode, for each complete block k of the effective length, the block tests the window at base + k*BLOCK_BYTES and then the window at base + k*BLOCK_BYTES + BLOCK_BYTES - WIN_BYTES, each `WIN_BYTES` long, blocks in ascending order.
- R6: In slow mode the whole effective length starting at the base address is tested as one window, including lengths that are not a multiple of a block.
- R7: The effective length is the requested length capped at `CAP_BYTES`, minus `TRIM_BYTES` (zero if that is not positive); an effective length that yields no window finishes the run with `done` and no memory access.
- R8: `fail` and the three capture values are cleared when a run starts and otherwise hold their value until the next start.
- R9: `busy` is high while a run is in progress, `done` is a single-cycle pulse ending each run, no memory access happens while `busy` is low, and `start` while busy is ignored.
- R10: The index used by the R1 patterns restarts at zero at the start of every window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken while idle) |
| slow_mode | input | 1 | 1: test the whole region; 0: sample windows around block boundaries |
| region_base | input | ADDR_W | Byte address of the region start |
| region_bytes | input | ADDR_W | Requested region length in bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | A mismatch ended the last run |
| fail_addr | output | ADDR_W | Byte address of the mismatch |
| fail_expect | output | DATA_W | Word that was expected |
| fail_read | output | DATA_W | Word that was read |
| wdog_kick | output | 1 | Watchdog service pulse |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after mem_re |

## Verification
A wrong test counter or index shows at once on `mem_wdata` and `mem_addr`, in the first write after the slip, so the bench records every access and compares the whole stream against a model built from the requirements. A wrong window or block counter moves the next window's addresses and shows in the first access of that window. A stuck compare path shows only when a mismatch is injected, so a memory fault is planted and the stop point, the captured values and the silence after it are checked. Kick-count errors accumulate over a run and are compared at its end.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

   // test sequence, in execution order
   typedef enum logic [2:0] {
      PAT_ZERO   = 3'd0,
      PAT_ONES   = 3'd1,
      PAT_ALT01  = 3'd2,
      PAT_ALT10  = 3'd3,
      PAT_WALK   = 3'd4,
      PAT_INDEX  = 3'd5,
      PAT_NINDEX = 3'd6
   } pat_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_FILL,
      ST_RDREQ,
      ST_CMP,
      ST_TEND,
      ST_FIN
   } seq_st_e;

endpackage

// File: rtl/mtest_patgen.sv
module mtest_patgen
   import mtest_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 16
) (
   input  pat_e              sel,
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   localparam int unsigned SH_W = $clog2(DATA_W);

   logic [DATA_W-1:0] idx_w;
   logic [DATA_W-1:0] walk;
   logic [SH_W-1:0]   bitpos;

   assign idx_w  = DATA_W'(idx);
   assign bitpos = SH_W'(idx);   // index mod DATA_W (DATA_W is a power of two)
   assign walk   = {{(DATA_W-1){1'b0}}, 1'b1} << bitpos;

   always_comb begin
      case (sel)
         PAT_ZERO:   word = '0;
         PAT_ONES:   word = '1;
         PAT_ALT01:  word = {(DATA_W/2){2'b01}};
         PAT_ALT10:  word = {(DATA_W/2){2'b10}};
         PAT_WALK:   word = walk;
         PAT_INDEX:  word = idx_w;
         PAT_NINDEX: word = ~idx_w;
         default:    word = '0;
      endcase
   end
endmodule

// File: rtl/mtest_window.sv
module mtest_window #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 16,
   parameter int unsigned BLK_W       = 9,
   parameter int unsigned WB_SH       = 2,
   parameter int unsigned BLOCK_BYTES = 1 << 20,
   parameter int unsigned WIN_BYTES   = 2048,
   parameter int unsigned CAP_BYTES   = 1 << 28,
   parameter int unsigned TRIM_BYTES  = 1 << 20
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] req_bytes,
   input  logic              slow,
   input  logic [BLK_W-1:0]  blk,
   input  logic              side,
   output logic [ADDR_W-1:0] win_base,
   output logic [IDX_W-1:0]  win_last,
   output logic [BLK_W-1:0]  nblocks,
   output logic              empty
);
   localparam int unsigned BLK_SH    = $clog2(BLOCK_BYTES);
   localparam int unsigned WIN_WORDS = WIN_BYTES >> WB_SH;

   logic [ADDR_W-1:0] capped;
   logic [ADDR_W-1:0] eff;
   logic [IDX_W-1:0]  slow_words;
   logic [ADDR_W-1:0] blk_off;

   assign capped = (req_bytes > ADDR_W'(CAP_BYTES)) ? ADDR_W'(CAP_BYTES) : req_bytes;

   generate
      if (TRIM_BYTES == 0) begin : g_notrim
         assign eff = capped;
      end else begin : g_trim
         assign eff = (capped > ADDR_W'(TRIM_BYTES)) ? capped - ADDR_W'(TRIM_BYTES) : '0;
      end
   endgenerate

   assign slow_words = IDX_W'(eff >> WB_SH);
   assign nblocks    = BLK_W'(eff >> BLK_SH);
   assign blk_off    = ADDR_W'(blk) << BLK_SH;

   always_comb begin
      if (slow) begin
         win_base = base_addr;
         win_last = slow_words - 1'b1;
         empty    = (slow_words == '0);
      end else begin
         win_base = base_addr + blk_off +
                    (side ? ADDR_W'(BLOCK_BYTES - WIN_BYTES) : '0);
         win_last = IDX_W'(WIN_WORDS - 1);
         empty    = (nblocks == '0);
      end
   end
endmodule

// File: rtl/mtest_seq.sv
module mtest_seq
   import mtest_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BLOCK_BYTES = 1 << 20,
   parameter int unsigned WIN_BYTES   = 2048,
   parameter int unsigned CAP_BYTES   = 1 << 28,
   parameter int unsigned TRIM_BYTES  = 1 << 20,
   parameter int unsigned KICK_WORDS  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              slow_mode,
   input  logic [ADDR_W-1:0] region_base,
   input  logic [ADDR_W-1:0] region_bytes,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [DATA_W-1:0] fail_expect,
   output logic [DATA_W-1:0] fail_read,
   output logic              wdog_kick,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int unsigned WB      = DATA_W / 8;
   localparam int unsigned WB_SH   = $clog2(WB);
   localparam int unsigned IDX_W   = $clog2(CAP_BYTES / WB) + 1;
   localparam int unsigned BLK_W   = $clog2(CAP_BYTES / BLOCK_BYTES) + 1;
   localparam int unsigned KICK_SH = $clog2(KICK_WORDS);

   initial begin
      assert ((DATA_W >= 8) && (DATA_W == (1 << $clog2(DATA_W))))
         else $error("DATA_W must be a power of two of at least 8");
      assert (BLOCK_BYTES == (1 << $clog2(BLOCK_BYTES)))
         else $error("BLOCK_BYTES must be a power of two");
      assert ((WIN_BYTES % WB == 0) && (2 * WIN_BYTES <= BLOCK_BYTES) && (WIN_BYTES >= WB))
         else $error("WIN_BYTES must be whole words and fit twice in a block");
      assert ((KICK_WORDS >= 2) && (KICK_WORDS == (1 << KICK_SH)))
         else $error("KICK_WORDS must be a power of two of at least 2");
      assert ((CAP_BYTES >= BLOCK_BYTES) && (ADDR_W > $clog2(CAP_BYTES)))
         else $error("CAP_BYTES must hold a block and fit in ADDR_W");
   end

   seq_st_e           state;
   pat_e              test;
   logic [IDX_W-1:0]  idx;
   logic [BLK_W-1:0]  blk;
   logic              side;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] size_q;
   logic              slow_q;

   logic [ADDR_W-1:0] win_base;
   logic [IDX_W-1:0]  win_last;
   logic [BLK_W-1:0]  nblocks;
   logic              empty;
   logic [DATA_W-1:0] pat_word;
   logic [ADDR_W-1:0] word_addr;
   logic              last_word;
   logic              stride_hit;

   mtest_window #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BLK_W(BLK_W), .WB_SH(WB_SH),
      .BLOCK_BYTES(BLOCK_BYTES), .WIN_BYTES(WIN_BYTES),
      .CAP_BYTES(CAP_BYTES), .TRIM_BYTES(TRIM_BYTES)
   ) u_win (
      .base_addr(base_q), .req_bytes(size_q), .slow(slow_q),
      .blk(blk), .side(side),
      .win_base(win_base), .win_last(win_last),
      .nblocks(nblocks), .empty(empty)
   );

   mtest_patgen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pat (
      .sel(test), .idx(idx), .word(pat_word)
   );

   assign word_addr  = win_base + (ADDR_W'(idx) << WB_SH);
   assign last_word  = (idx == win_last);
   assign stride_hit = (idx[KICK_SH-1:0] == '0);

   assign busy      = (state != ST_IDLE) && (state != ST_FIN);
   assign done      = (state == ST_FIN);
   assign mem_we    = (state == ST_FILL);
   assign mem_re    = (state == ST_RDREQ);
   assign mem_addr  = word_addr;
   assign mem_wdata = pat_word;
   assign wdog_kick = ((mem_we || mem_re) && stride_hit) || (state == ST_TEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         test        <= PAT_ZERO;
         idx         <= '0;
         blk         <= '0;
         side        <= 1'b0;
         base_q      <= '0;
         size_q      <= '0;
         slow_q      <= 1'b0;
         fail        <= 1'b0;
         fail_addr   <= '0;
         fail_expect <= '0;
         fail_read   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  base_q      <= region_base;
                  size_q      <= region_bytes;
                  slow_q      <= slow_mode;
                  fail        <= 1'b0;
                  fail_addr   <= '0;
                  fail_expect <= '0;
                  fail_read   <= '0;
                  state       <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               test  <= PAT_ZERO;
               idx   <= '0;
               blk   <= '0;
               side  <= 1'b0;
               state <= empty ? ST_FIN : ST_FILL;
            end
            ST_FILL: begin
               if (last_word) begin
                  idx   <= '0;
                  state <= ST_RDREQ;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_RDREQ: state <= ST_CMP;
            ST_CMP: begin
               if (mem_rdata != pat_word) begin
                  fail        <= 1'b1;
                  fail_addr   <= word_addr;
                  fail_expect <= pat_word;
                  fail_read   <= mem_rdata;
                  state       <= ST_FIN;
               end else if (last_word) begin
                  state <= ST_TEND;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= ST_RDREQ;
               end
            end
            ST_TEND: begin
               idx <= '0;
               if (test != PAT_NINDEX) begin
                  test  <= pat_e'(test + 3'd1);
                  state <= ST_FILL;
               end else if (slow_q) begin
                  state <= ST_FIN;
               end else if (!side) begin
                  side  <= 1'b1;
                  test  <= PAT_ZERO;
                  state <= ST_FILL;
               end else if (blk == nblocks - 1'b1) begin
                  state <= ST_FIN;
               end else begin
                  blk   <= blk + 1'b1;
                  side  <= 1'b0;
                  test  <= PAT_ZERO;
                  state <= ST_FILL;
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mtest_seq_chk.sv
module mtest_seq_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic [ADDR_W-1:0] fail_addr,
   input logic [DATA_W-1:0] fail_expect,
   input logic [DATA_W-1:0] fail_read,
   input logic              wdog_kick,
   input logic              mem_we,
   input logic              mem_re
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                          // R9
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));                                    // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_we || mem_re));                           // R9
   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));                                     // R2
   AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !(mem_re || mem_we));                          // R2
   AST_FAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> done);                                    // R3
   AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !(mem_we || mem_re));                            // R3
   AST_KICK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_kick |-> busy);                                      // R4
   AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(fail) && $stable(fail_addr) &&
                              $stable(fail_expect) && $stable(fail_read))); // R8
endmodule

bind mtest_seq mtest_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .fail(fail), .fail_addr(fail_addr), .fail_expect(fail_expect),
   .fail_read(fail_read), .wdog_kick(wdog_kick),
   .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/mtest_seq_test.sv
module mtest_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int LOG_MAX    = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        slow_mode = 1'b0;
   logic [31:0] region_base = '0;
   logic [31:0] region_bytes = '0;
   logic        busy, done, fail, wdog_kick, mem_we, mem_re;
   logic [31:0] fail_addr, fail_expect, fail_read, mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // memory model with an optional stuck-at-0 fault
   logic [31:0] mem [0:511];
   logic        flt_en = 1'b0;
   logic [31:0] flt_addr = '0;
   logic [31:0] flt_clr = '0;

   // access log and expected stream
   logic        lk [0:LOG_MAX-1];
   logic [31:0] la [0:LOG_MAX-1];
   logic [31:0] ld [0:LOG_MAX-1];
   int          nlog = 0;
   logic        ek [0:LOG_MAX-1];
   logic [31:0] ea [0:LOG_MAX-1];
   logic [31:0] ed [0:LOG_MAX-1];
   int          nexp = 0;
   int          kicks = 0;
   int          dones = 0;

   mtest_seq #(
      .ADDR_W(32), .DATA_W(32), .BLOCK_BYTES(256), .WIN_BYTES(32),
      .CAP_BYTES(1024), .TRIM_BYTES(256), .KICK_WORDS(4)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .slow_mode(slow_mode),
      .region_base(region_base), .region_bytes(region_bytes),
      .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
      .fail_expect(fail_expect), .fail_read(fail_read), .wdog_kick(wdog_kick),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_re(mem_re), .mem_rdata(mem_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (mem_we)
         mem[mem_addr[10:2]] <= (flt_en && mem_addr == flt_addr) ? (mem_wdata & ~flt_clr) : mem_wdata;
      if (mem_re)
         mem_rdata <= mem[mem_addr[10:2]];
   end

   always @(negedge clk) begin
      if ((mem_we || mem_re) && nlog < LOG_MAX) begin
         lk[nlog] = mem_we;
         la[nlog] = mem_addr;
         ld[nlog] = mem_we ? mem_wdata : 32'h0;
         nlog = nlog + 1;
      end
      if (wdog_kick) kicks = kicks + 1;
      if (done) dones = dones + 1;
   end

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int t, input int i);
      case (t)
         0: return 32'h0000_0000;
         1: return 32'hFFFF_FFFF;
         2: return 32'h5555_5555;
         3: return 32'hAAAA_AAAA;
         4: return 32'h1 << (i % 32);
         5: return 32'(i);
         default: return ~32'(i);
      endcase
   endfunction

   task automatic add_window(input logic [31:0] base, input int n);
      for (int t = 0; t < 7; t++) begin
         for (int i = 0; i < n; i++) begin
            ek[nexp] = 1'b1; ea[nexp] = base + 32'(4*i); ed[nexp] = pat(t, i); nexp++;
         end
         for (int i = 0; i < n; i++) begin
            ek[nexp] = 1'b0; ea[nexp] = base + 32'(4*i); ed[nexp] = 32'h0; nexp++;
         end
      end
   endtask

   // expected stream from R5/R6/R7: cap 1024, trim 256, block 256, window 32
   task automatic build(input logic slow, input logic [31:0] base, input int size);
      int capped, eff;
      capped = (size > 1024) ? 1024 : size;
      eff = (capped > 256) ? capped - 256 : 0;
      nexp = 0;
      if (slow) begin
         if (eff / 4 > 0) add_window(base, eff / 4);
      end else begin
         for (int b = 0; b < eff / 256; b++) begin
            add_window(base + 32'(b*256), 8);
            add_window(base + 32'(b*256 + 224), 8);
         end
      end
   endtask

   task automatic check_stream(input string req, input int count);
      int bad;
      bad = -1;
      check(req, "access count", 32'(nlog), 32'(count));
      for (int k = 0; k < count && k < nlog; k++)
         if (bad < 0 && (lk[k] !== ek[k] || la[k] !== ea[k] || (ek[k] && ld[k] !== ed[k])))
            bad = k;
      checks++;
      if (bad >= 0) begin
         failures++;
         $display("FAIL %s access %0d: actual we=%b addr=%h data=%h expected we=%b addr=%h data=%h",
                  req, bad, lk[bad], la[bad], ld[bad], ek[bad], ea[bad], ed[bad]);
      end
   endtask

   task automatic run(input logic slow, input logic [31:0] base, input int size, input logic chk_clear);
      nlog = 0; kicks = 0; dones = 0;
      @(negedge clk);
      slow_mode = slow; region_base = base; region_bytes = 32'(size); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (chk_clear) begin
         check("R8", "fail cleared on start", {31'b0, fail}, 32'h0);
         check("R8", "fail_addr cleared on start", fail_addr, 32'h0);
      end
      check("R9", "busy after start", {31'b0, busy}, 32'h1);
      while (dones == 0 && cycles < 150000) @(posedge clk);
      repeat (3) @(negedge clk);
      check("R9", "single done pulse", 32'(dones), 32'h1);
      check("R9", "idle after done", {31'b0, busy}, 32'h0);
   endtask

   task automatic t_reset();
      check("R9", "reset busy", {31'b0, busy}, 32'h0);
      check("R9", "reset done", {31'b0, done}, 32'h0);
      check("R3", "reset fail", {31'b0, fail}, 32'h0);
      check("R4", "reset kick", {31'b0, wdog_kick}, 32'h0);
      check("R9", "reset no access", {30'b0, mem_we, mem_re}, 32'h0);
   endtask

   task automatic t_slow_full();   // R1 R2 R4 R6 R10: 512 bytes -> 256 effective, 64 words
      run(1'b1, 32'h400, 512, 1'b0);
      build(1'b1, 32'h400, 512);
      check_stream("R1", nexp);
      check("R4", "kick count slow", 32'(kicks), 32'(7 * (16 + 16 + 1)));
      check("R3", "no fail slow", {31'b0, fail}, 32'h0);
   endtask

   task automatic t_slow_odd();    // R6: 300 bytes -> 44 effective, 11 words
      run(1'b1, 32'h400, 300, 1'b0);
      build(1'b1, 32'h400, 300);
      check_stream("R6", nexp);
      check("R4", "kick count odd", 32'(kicks), 32'(7 * (3 + 3 + 1)));
   endtask

   task automatic t_normal_capped();  // R5 R7 R10: 0x2000 capped to 1024 -> 768, three blocks
      run(1'b0, 32'h400, 32'h2000, 1'b0);
      build(1'b0, 32'h400, 32'h2000);
      check_stream("R5", nexp);
      check("R5", "window count", 32'(nexp), 32'(6 * 7 * 16));
      check("R4", "kick count normal", 32'(kicks), 32'(6 * 7 * 5));
   endtask

   task automatic t_empty();       // R7: effective length gives no window
      run(1'b0, 32'h400, 300, 1'b0);
      check("R7", "normal short no access", 32'(nlog), 32'h0);
      run(1'b1, 32'h400, 256, 1'b0);
      check("R7", "slow trimmed to zero no access", 32'(nlog), 32'h0);
      check("R7", "no kicks when empty", 32'(kicks), 32'h0);
   endtask

   task automatic t_fault();       // R3: bit 0 stuck low at word 3
      flt_en = 1'b1; flt_addr = 32'h40C; flt_clr = 32'h1;
      run(1'b1, 32'h400, 512, 1'b0);
      build(1'b1, 32'h400, 512);
      check_stream("R3", 128 + 64 + 4);
      check("R3", "fail flag", {31'b0, fail}, 32'h1);
      check("R3", "fail_addr", fail_addr, 32'h40C);
      check("R3", "fail_expect", fail_expect, 32'hFFFF_FFFF);
      check("R3", "fail_read", fail_read, 32'hFFFF_FFFE);
      check("R4", "kick count to fault", 32'(kicks), 32'(33 + 16 + 1));
      flt_en = 1'b0;
   endtask

   task automatic t_hold_clear();  // R8
      repeat (20) @(negedge clk);
      check("R8", "fail held", {31'b0, fail}, 32'h1);
      check("R8", "fail_addr held", fail_addr, 32'h40C);
      check("R8", "fail_read held", fail_read, 32'hFFFF_FFFE);
      run(1'b1, 32'h400, 300, 1'b1);
      check("R8", "clean run leaves fail low", {31'b0, fail}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_slow_full();
      t_slow_odd();
      t_normal_capped();
      t_empty();
      t_fault();
      t_hold_clear();
      if (cycles >= 150000) begin
         failures++;
         $display("FAIL watchdog: actual=%0d cycles expected below 150000", cycles);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles >= 160000);
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule